// File: doc/BRIEF.md
# Dual-Rate PWM LED Dimming Engine

This block turns a small set of configuration bytes into drive controls for sixteen open-drain LED pads. Two independent dimming channels run from one shared timebase tick. Each channel has an 8-bit prescaler that sets its period and an 8-bit duty value that sets how long the LED stays lit in each period. Every pad then picks one of four sources through its own 2-bit selector: released, held low, channel 0 or channel 1.

The timebase is a tick enable that fires once every `TICK_DIV` clocks. Its nominal rate is 40.96 kHz, which is 256 phase steps at 160 Hz. Each channel's 8-bit phase counter advances once every `PSC+1` ticks, so a full period is `(PSC+1)/160` s at the nominal rate. The pad sinks current while the phase is below the duty value.

Prescaler and duty values pass into a channel only when its phase wraps. A change made part way through a period therefore never produces a shortened or stretched pulse. The configuration bytes come from an external register file. The engine only samples them.

Top module: `led_dim_engine`

## Requirements
- R1: The tick enable fires once every `TICK_DIV` clocks. A channel's phase advances by exactly one on every `(PSC+1)`-th tick and wraps from 255 to 0, so one period lasts `256*(PSC+1)` ticks.
- R2: A pad that follows a channel sinks current exactly while that channel's phase is below its duty value.
- R3: A duty value of 0 keeps every pad following that channel released for the whole period.
- R4: While reset is high, all pads are released. After reset, each channel runs with prescaler 0 and duty 0x80 until its first wrap, whatever values are on the configuration inputs.
- R5: Selector code 2'b00 releases the pad, 2'b01 holds it low, 2'b10 makes it follow channel 0, and 2'b11 makes it follow channel 1.
- R6: Pad i takes its selector from `cfg_sel[2*i+1:2*i]`. Pad 0 uses the least significant pair of bits and pad 15 the most significant pair.
- R7: New prescaler and duty values on the inputs take effect only at the channel's next phase wrap. Until then the previous values stay in force.
- R8: The two channels count independently. Settings on one channel never change the waveform of the other.
- R9: Pad outputs are registered and reflect the selector and channel state one clock after they are sampled. A sinking pad has both `led_sink` and `led_oe` high, and a released pad has both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_psc0 | input | 8 | Channel 0 prescaler |
| cfg_duty0 | input | 8 | Channel 0 duty value |
| cfg_psc1 | input | 8 | Channel 1 prescaler |
| cfg_duty1 | input | 8 | Channel 1 duty value |
| cfg_sel | input | 2*NUM_PINS | Per-pad 2-bit source selectors, pad i at bits 2i+1:2i |
| led_sink | output | NUM_PINS | Pad pulls low when 1 |
| led_oe | output | NUM_PINS | Pad output driver enabled when 1 (released when 0) |

## Verification
A wrong prescale or phase count shows at the pads as an edge that comes early or late against a count the bench works out arithmetically. A count that is off by one stays visible until the end of the period, because every later edge in that period moves with it. If shadow values are loaded at the wrong moment, the duty edge moves in the same period as the input change instead of after the wrap, and that is seen within one period. A fault in selector decoding or in the bit layout shows on the next clock after a selector change. The bench walks every code across every pad to catch it.

// File: rtl/led_dim_pkg.sv
package led_dim_pkg;

    localparam int CNT_W  = 8;
    localparam int SEL_W  = 2;
    localparam int NUM_CH = 2;

    localparam logic [CNT_W-1:0] PSC_DEFAULT  = 8'h00;
    localparam logic [CNT_W-1:0] DUTY_DEFAULT = 8'h80;

    typedef enum logic [SEL_W-1:0] {
        SRC_RELEASE = 2'b00,
        SRC_LOW     = 2'b01,
        SRC_CH0     = 2'b10,
        SRC_CH1     = 2'b11
    } pad_src_e;

    typedef struct packed {
        logic [CNT_W-1:0] psc;
        logic [CNT_W-1:0] duty;
    } dim_cfg_t;

    typedef struct packed {
        logic sink;
        logic oe;
    } pad_drv_t;

    function automatic pad_drv_t pad_decode(pad_src_e src, logic ch0_on, logic ch1_on);
        pad_drv_t drv;
        logic     lit;
        case (src)
            SRC_LOW:  lit = 1'b1;
            SRC_CH0:  lit = ch0_on;
            SRC_CH1:  lit = ch1_on;
            default:  lit = 1'b0;
        endcase
        drv.sink = lit;
        drv.oe   = lit;
        return drv;
    endfunction

endpackage

// File: rtl/dim_tick_gen.sv
module dim_tick_gen #(
    parameter int DIV = 3052
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    generate
        if (DIV <= 1) begin : g_every
            assign tick_o = !rst;
        end else begin : g_count
            localparam int CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk) begin
                if (rst)                cnt_q <= '0;
                else if (cnt_q == LAST) cnt_q <= '0;
                else                    cnt_q <= cnt_q + 1'b1;
            end

            assign tick_o = !rst && (cnt_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/dim_channel.sv
module dim_channel
    import led_dim_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  dim_cfg_t         cfg_i,
    output logic             on_o,
    output logic [CNT_W-1:0] phase_o,
    output logic [CNT_W-1:0] duty_o
);
    dim_cfg_t         act_q;
    logic [CNT_W-1:0] pre_q;
    logic [CNT_W-1:0] phase_q;
    logic             step;
    logic             wrap;

    assign step = tick_i && (pre_q == act_q.psc);
    assign wrap = step && (phase_q == '1);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q.psc  <= PSC_DEFAULT;
            act_q.duty <= DUTY_DEFAULT;
            pre_q      <= '0;
            phase_q    <= '0;
        end else if (tick_i) begin
            pre_q <= step ? '0 : pre_q + 1'b1;
            if (step) phase_q <= phase_q + 1'b1;
            if (wrap) act_q   <= cfg_i;
        end
    end

    assign on_o    = phase_q < act_q.duty;
    assign phase_o = phase_q;
    assign duty_o  = act_q.duty;
endmodule

// File: rtl/dim_pad_mux.sv
module dim_pad_mux
    import led_dim_pkg::*;
#(
    parameter int NUM_PINS = 16
) (
    input  logic [SEL_W*NUM_PINS-1:0] sel_i,
    input  logic [NUM_CH-1:0]         ch_on_i,
    output logic [NUM_PINS-1:0]       sink_o,
    output logic [NUM_PINS-1:0]       oe_o
);
    generate
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_pad
            pad_drv_t drv;
            assign drv       = pad_decode(pad_src_e'(sel_i[SEL_W*p +: SEL_W]),
                                          ch_on_i[0], ch_on_i[1]);
            assign sink_o[p] = drv.sink;
            assign oe_o[p]   = drv.oe;
        end
    endgenerate
endmodule

// File: rtl/led_dim_engine.sv
module led_dim_engine
    import led_dim_pkg::*;
#(
    parameter int NUM_PINS = 16,
    parameter int TICK_DIV = 3052
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [CNT_W-1:0]          cfg_psc0,
    input  logic [CNT_W-1:0]          cfg_duty0,
    input  logic [CNT_W-1:0]          cfg_psc1,
    input  logic [CNT_W-1:0]          cfg_duty1,
    input  logic [SEL_W*NUM_PINS-1:0] cfg_sel,
    output logic [NUM_PINS-1:0]       led_sink,
    output logic [NUM_PINS-1:0]       led_oe
);
    logic                             tick;
    dim_cfg_t                         ch_cfg [NUM_CH];
    logic [NUM_CH-1:0]                ch_on;
    logic [NUM_CH-1:0][CNT_W-1:0]     ch_phase;
    logic [NUM_CH-1:0][CNT_W-1:0]     ch_duty;
    logic [NUM_PINS-1:0]              sink_d;
    logic [NUM_PINS-1:0]              oe_d;

    assign ch_cfg[0] = '{psc: cfg_psc0, duty: cfg_duty0};
    assign ch_cfg[1] = '{psc: cfg_psc1, duty: cfg_duty1};

    dim_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            dim_channel u_ch (
                .clk     (clk),
                .rst     (rst),
                .tick_i  (tick),
                .cfg_i   (ch_cfg[c]),
                .on_o    (ch_on[c]),
                .phase_o (ch_phase[c]),
                .duty_o  (ch_duty[c])
            );
        end
    endgenerate

    dim_pad_mux #(.NUM_PINS(NUM_PINS)) u_mux (
        .sel_i   (cfg_sel),
        .ch_on_i (ch_on),
        .sink_o  (sink_d),
        .oe_o    (oe_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            led_sink <= '0;
            led_oe   <= '0;
        end else begin
            led_sink <= sink_d;
            led_oe   <= oe_d;
        end
    end
endmodule

// File: rtl/led_dim_checker.sv
module led_dim_checker #(
    parameter int NUM_PINS = 16
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    tick,
    input logic [2*NUM_PINS-1:0]   cfg_sel,
    input logic [NUM_PINS-1:0]     led_sink,
    input logic [NUM_PINS-1:0]     led_oe,
    input logic [1:0]              ch_on,
    input logic [1:0][7:0]         ch_phase,
    input logic [1:0][7:0]         ch_duty
);
    AST_RESET_RELEASED: assert property (@(posedge clk)
        rst |=> (led_oe == '0)); // R4

    AST_PHASE0_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(ch_phase[0])); // R1

    AST_PHASE0_STEP: assert property (@(posedge clk) disable iff (rst)
        tick |=> (ch_phase[0] == $past(ch_phase[0]) || ch_phase[0] == $past(ch_phase[0]) + 8'd1)); // R1

    AST_PHASE1_STEP: assert property (@(posedge clk) disable iff (rst)
        tick |=> (ch_phase[1] == $past(ch_phase[1]) || ch_phase[1] == $past(ch_phase[1]) + 8'd1)); // R8

    AST_DUTY0_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
        !$stable(ch_duty[0]) |-> (ch_phase[0] == 8'h00)); // R7

    AST_DUTY1_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
        !$stable(ch_duty[1]) |-> (ch_phase[1] == 8'h00)); // R7

    AST_DUTY_ZERO_DARK: assert property (@(posedge clk) disable iff (rst)
        (ch_duty[0] == 8'h00) |-> !ch_on[0]); // R3

    AST_PAD0_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (cfg_sel[1:0] == 2'b00) |=> !led_oe[0]); // R5

    AST_PAD0_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (cfg_sel[1:0] == 2'b10) |=> (led_sink[0] == $past(ch_on[0]))); // R2

    AST_PAD15_LOW: assert property (@(posedge clk) disable iff (rst)
        (cfg_sel[2*NUM_PINS-1 -: 2] == 2'b01) |=> led_sink[NUM_PINS-1]); // R6

    AST_PAD15_CH1: assert property (@(posedge clk) disable iff (rst)
        (cfg_sel[2*NUM_PINS-1 -: 2] == 2'b11) |=> (led_oe[NUM_PINS-1] == $past(ch_on[1]))); // R9
endmodule

bind led_dim_engine led_dim_checker #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .cfg_sel  (cfg_sel),
    .led_sink (led_sink),
    .led_oe   (led_oe),
    .ch_on    (ch_on),
    .ch_phase (ch_phase),
    .ch_duty  (ch_duty)
);

// File: tb/led_dim_engine_tb.sv
module led_dim_engine_tb;
    localparam int NP   = 16;
    localparam int TDIV = 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [7:0]      cfg_psc0, cfg_duty0, cfg_psc1, cfg_duty1;
    logic [2*NP-1:0] cfg_sel;
    logic [NP-1:0]   led_sink, led_oe;

    int checks = 0;
    int fails  = 0;
    int k      = 0;
    int st [2];
    int pc [2];
    int dc [2];

    always #4 clk = ~clk;

    led_dim_engine #(.NUM_PINS(NP), .TICK_DIV(TDIV)) u_dut (
        .clk(clk), .rst(rst),
        .cfg_psc0(cfg_psc0), .cfg_duty0(cfg_duty0),
        .cfg_psc1(cfg_psc1), .cfg_duty1(cfg_duty1),
        .cfg_sel(cfg_sel), .led_sink(led_sink), .led_oe(led_oe)
    );

    task automatic compare(string tag, logic [NP-1:0] act, logic [NP-1:0] exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s cycle %0d: actual %h expected %h", tag, what, k, act, exp);
        end
    endtask

    // Arithmetic expectation: n ticks seen before the sampling edge,
    // each channel restarts its epoch at every 256*(psc+1) ticks.
    task automatic check_cycle(string tag);
        int n;
        int ph;
        logic [1:0] on;
        logic [NP-1:0] exp;
        n = (k - 1) / TDIV;
        for (int c = 0; c < 2; c++) begin
            while (n - st[c] >= 256 * (pc[c] + 1)) begin
                st[c] += 256 * (pc[c] + 1);
                pc[c] = (c == 0) ? int'(cfg_psc0)  : int'(cfg_psc1);
                dc[c] = (c == 0) ? int'(cfg_duty0) : int'(cfg_duty1);
            end
            ph = (n - st[c]) / (pc[c] + 1);
            on[c] = ph < dc[c];
        end
        for (int i = 0; i < NP; i++) begin
            case (cfg_sel[2*i +: 2])
                2'b01:   exp[i] = 1'b1;
                2'b10:   exp[i] = on[0];
                2'b11:   exp[i] = on[1];
                default: exp[i] = 1'b0;
            endcase
        end
        compare(tag, led_sink, exp, "led_sink");
        compare(tag, led_oe,   exp, "led_oe");
    endtask

    task automatic run(int cycles, string tag);
        for (int j = 0; j < cycles; j++) begin
            @(posedge clk);
            k++;
            @(negedge clk);
            check_cycle(tag);
        end
    endtask

    initial begin
        #(8 * 300000);
        fails++;
        $display("FAIL watchdog expired: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // Non-default inputs during reset: R4 says they are ignored until the first wrap.
        cfg_psc0 = 8'd3; cfg_duty0 = 8'h20;
        cfg_psc1 = 8'd1; cfg_duty1 = 8'hF0;
        cfg_sel  = 32'hFFFF_AAAA;
        for (int c = 0; c < 2; c++) begin
            st[c] = 0; pc[c] = 0; dc[c] = 8'h80;
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        compare("R4", led_oe,   '0, "led_oe in reset");
        compare("R4", led_sink, '0, "led_sink in reset");
        rst = 1'b0;

        run(512, "R4");                    // default period, psc 0 duty 0x80
        run(4096, "R1 R2 R8");             // ch0 psc3 duty 0x20, ch1 psc1 duty 0xF0

        for (int r = 0; r < 4; r++) begin  // every code on every pad: R5 R6
            for (int i = 0; i < NP; i++) cfg_sel[2*i +: 2] = 2'((i + r) % 4);
            run(300, "R5 R6");
        end

        for (int i = 0; i < NP; i++) begin // single pad held low walks across: R6 R9
            cfg_sel = '0;
            cfg_sel[2*i +: 2] = 2'b01;
            run(3, "R6 R9");
        end

        cfg_sel  = 32'hFFFF_AAAA;
        run(700, "R2");
        cfg_psc0 = 8'd0; cfg_duty0 = 8'h00; // mid-period change, applies at wrap only
        run(2600, "R3 R7");

        cfg_duty0 = 8'hFF; cfg_psc1 = 8'd0; cfg_duty1 = 8'h01;
        run(3000, "R2 R8");

        cfg_sel = 32'h5555_0000;
        run(20, "R5");
        cfg_sel = 32'h0000_0000;
        run(20, "R5");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule